// File: doc/BRIEF.md
# Message and doorbell interrupt unit

This block is a small register file that sits between a host bus master and a local processor. The two sides use it to pass short words and interrupt requests to each other. Each direction has two 32-bit message registers, a 32-bit doorbell, a status register and a mask register. The host writes the inbound set, and that raises the local interrupt. The local processor writes the outbound set, and that raises the host interrupt.

Each side has a one-word write port and a combinational read port over eight word offsets. The same offsets are used on both sides and carry the same roles from that side's point of view:

| Offset | Role |
|---|---|
| 0, 1 | message n that this side sends |
| 2 | doorbell that this side rings |
| 3, 4 | peer's message n, read-only |
| 5 | doorbell that this side acknowledges |
| 6 | status of the direction that this side receives |
| 7 | mask of the direction that this side receives |

Level inputs from the queue logic, which lies outside this block, feed the remaining status bits.

Top module: `msgdb_unit`

## Requirements
- R1: After reset every message, doorbell and message-status bit is zero. Both interrupt outputs are low. The local mask (offset 7) reads 0x1BB and the host mask reads 0x2B, which means every implemented source is masked.
- R2: A write to offset 0 or 1 stores the word as message n of that direction and sets status bit n of that direction. The word is read back at the sender's offset n and at the receiver's offset 3+n.
- R3: Writing ones to status bits 1:0 at offset 6 clears those message bits. If a message write and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A host write to offset 2 ORs the written ones into the inbound doorbell.
- R5: A local write to offset 2 ORs only bits 28:0 into the outbound doorbell. Bits 31:29 of the outbound doorbell stay zero.
- R6: Writing ones at offset 5 clears those doorbell bits. If a ring and a clear land in the same cycle, the ring wins. Status bit 3 is 1 exactly while the doorbell is non-zero.
- R7: Inbound status (local offset 6) is laid out as follows: bit 4 is the machine-check input, bit 5 is inbound post pending, bit 7 is post overflow and bit 8 is free overflow. These bits follow their inputs live. Bits 2 and 6 read zero, and so do bits 31:9.
- R8: Outbound status (host offset 6) bit 5 follows the outbound-post input. Its bits 2, 4 and 31:6 read zero.
- R9: A write to offset 7 stores the implemented mask bits (0x1BB inbound, 0x2B outbound). The other bits read zero. Mask contents change only through this write.
- R10: Each interrupt output is the OR over the bits of its direction's status AND NOT mask. A mask bit of 1 disables that source.
- R11: Writes to offsets 3 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| h_we | input | 1 | host write strobe |
| h_addr | input | 3 | host word offset |
| h_wdata | input | 32 | host write data |
| h_rdata | output | 32 | host read data for h_addr |
| l_we | input | 1 | local write strobe |
| l_addr | input | 3 | local word offset |
| l_wdata | input | 32 | local write data |
| l_rdata | output | 32 | local read data for l_addr |
| ev_mcheck | input | 1 | machine-check level, inbound status bit 4 |
| ev_in_post | input | 1 | inbound post queue non-empty, inbound bit 5 |
| ev_in_post_ovf | input | 1 | inbound post queue overflow, inbound bit 7 |
| ev_free_ovf | input | 1 | free queue overflow, inbound bit 8 |
| ev_out_post | input | 1 | outbound post queue non-empty, outbound bit 5 |
| host_irq | output | 1 | interrupt towards the host (outbound direction) |
| loc_irq | output | 1 | interrupt towards the local processor (inbound direction) |

## Verification
The bench drives both ports in the same cycle so that a ring and an acknowledge, or a message write and a status clear, collide. A design that let the clear win there would lose an event and show a status or doorbell bit at 0 where 1 is expected. A local ring with all ones exposes a design that lets the local side set bits 31:29, because the host would read 0xFFFFFFFF instead of 0x1FFFFFFF. Partial doorbell clears show whether status bit 3 tracks the remaining ones or drops after the first acknowledge. Writes to the read-only peer offsets and to reserved mask bits catch a decoder that aliases them onto live registers.

// File: rtl/msgdb_pkg.sv
package msgdb_pkg;

  // Word offsets, identical on both ports (roles seen from the accessing side)
  localparam logic [2:0] A_MSG0    = 3'd0;
  localparam logic [2:0] A_MSG1    = 3'd1;
  localparam logic [2:0] A_DB_SEND = 3'd2;
  localparam logic [2:0] A_PEER0   = 3'd3;
  localparam logic [2:0] A_PEER1   = 3'd4;
  localparam logic [2:0] A_DB_ACK  = 3'd5;
  localparam logic [2:0] A_STAT    = 3'd6;
  localparam logic [2:0] A_MASK    = 3'd7;

  localparam int N_MSG = 2;

  // Status bit positions
  localparam int SB_DB   = 3;
  localparam int SB_MCHK = 4;
  localparam int SB_POST = 5;
  localparam int SB_POVF = 7;
  localparam int SB_FOVF = 8;

  localparam int IN_STAT_W  = 9;
  localparam int OUT_STAT_W = 6;

  localparam logic [IN_STAT_W-1:0] IN_IMPL =
    IN_STAT_W'((1 << 0) | (1 << 1) | (1 << SB_DB) | (1 << SB_MCHK) |
               (1 << SB_POST) | (1 << SB_POVF) | (1 << SB_FOVF));
  localparam logic [OUT_STAT_W-1:0] OUT_IMPL =
    OUT_STAT_W'((1 << 0) | (1 << 1) | (1 << SB_DB) | (1 << SB_POST));

endpackage

// File: rtl/msgdb_rst_sync.sv
module msgdb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q   <= stage_q;
    end
  end
endmodule

// File: rtl/msgdb_dir.sv
// One signalling direction: sender writes messages / rings doorbell,
// receiver acknowledges, clears status and owns the mask.
module msgdb_dir
  import msgdb_pkg::*;
#(
  parameter int                DW          = 32,
  parameter int                STAT_W      = IN_STAT_W,
  parameter logic [STAT_W-1:0] IMPL        = IN_IMPL,
  parameter logic [DW-1:0]     DB_SET_MASK = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MSG-1:0]        msg_we,
  input  logic                    db_set_we,
  input  logic [DW-1:0]           snd_wdata,
  input  logic                    db_clr_we,
  input  logic                    stat_clr_we,
  input  logic                    mask_we,
  input  logic [DW-1:0]           rcv_wdata,
  input  logic [STAT_W-1:0]       ext_stat,
  output logic [N_MSG-1:0][DW-1:0] msg_q,
  output logic [DW-1:0]           db_q,
  output logic [STAT_W-1:0]       stat,
  output logic [STAT_W-1:0]       mask_q,
  output logic                    irq
);

  logic [N_MSG-1:0]  sm_q, sm_d;
  logic              sm_en;
  logic [DW-1:0]     db_d;
  logic              db_en;
  logic [STAT_W-1:0] mask_d;

  // next-state
  always_comb begin
    sm_en  = stat_clr_we | (|msg_we);
    sm_d   = (sm_q & ~(stat_clr_we ? rcv_wdata[N_MSG-1:0] : '0)) | msg_we;
    db_en  = db_clr_we | db_set_we;
    db_d   = (db_q & ~(db_clr_we ? rcv_wdata : '0)) |
             (db_set_we ? (snd_wdata & DB_SET_MASK) : '0);
    mask_d = rcv_wdata[STAT_W-1:0] & IMPL;
  end

  // registers
  generate
    for (genvar i = 0; i < N_MSG; i++) begin : g_msg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         msg_q[i] <= '0;
        else if (msg_we[i]) msg_q[i] <= snd_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sm_q   <= '0;
      db_q   <= '0;
      mask_q <= IMPL;
    end else begin
      if (sm_en)   sm_q   <= sm_d;
      if (db_en)   db_q   <= db_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  // status view and interrupt
  always_comb begin
    stat              = ext_stat & IMPL;
    stat[N_MSG-1:0]   = sm_q;
    stat[SB_DB]       = |db_q;
    irq               = |(stat & ~mask_q);
  end

endmodule

// File: rtl/msgdb_unit.sv
module msgdb_unit
  import msgdb_pkg::*;
#(
  parameter int DW         = 32,
  parameter int LOCAL_DB_W = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [2:0]    h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          l_we,
  input  logic [2:0]    l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          ev_mcheck,
  input  logic          ev_in_post,
  input  logic          ev_in_post_ovf,
  input  logic          ev_free_ovf,
  input  logic          ev_out_post,
  output logic          host_irq,
  output logic          loc_irq
);

  localparam logic [DW-1:0] LOC_DB_MASK =
    {{(DW-LOCAL_DB_W){1'b0}}, {LOCAL_DB_W{1'b1}}};

  logic rst_q;

  logic [N_MSG-1:0][DW-1:0] in_msg, out_msg;
  logic [DW-1:0]            in_db, out_db;
  logic [IN_STAT_W-1:0]     in_stat, in_mask, in_ext;
  logic [OUT_STAT_W-1:0]    out_stat, out_mask, out_ext;

  logic h_msg0, h_msg1, h_ring, h_ack, h_sclr, h_mwr;
  logic l_msg0, l_msg1, l_ring, l_ack, l_sclr, l_mwr;

  msgdb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  // write decode
  always_comb begin
    h_msg0 = h_we && (h_addr == A_MSG0);
    h_msg1 = h_we && (h_addr == A_MSG1);
    h_ring = h_we && (h_addr == A_DB_SEND);
    h_ack  = h_we && (h_addr == A_DB_ACK);
    h_sclr = h_we && (h_addr == A_STAT);
    h_mwr  = h_we && (h_addr == A_MASK);
    l_msg0 = l_we && (l_addr == A_MSG0);
    l_msg1 = l_we && (l_addr == A_MSG1);
    l_ring = l_we && (l_addr == A_DB_SEND);
    l_ack  = l_we && (l_addr == A_DB_ACK);
    l_sclr = l_we && (l_addr == A_STAT);
    l_mwr  = l_we && (l_addr == A_MASK);
  end

  always_comb begin
    in_ext           = '0;
    in_ext[SB_MCHK]  = ev_mcheck;
    in_ext[SB_POST]  = ev_in_post;
    in_ext[SB_POVF]  = ev_in_post_ovf;
    in_ext[SB_FOVF]  = ev_free_ovf;
    out_ext          = '0;
    out_ext[SB_POST] = ev_out_post;
  end

  msgdb_dir #(
    .DW(DW), .STAT_W(IN_STAT_W), .IMPL(IN_IMPL), .DB_SET_MASK('1)
  ) u_in (
    .clk(clk), .rst_n(rst_q),
    .msg_we({h_msg1, h_msg0}), .db_set_we(h_ring), .snd_wdata(h_wdata),
    .db_clr_we(l_ack), .stat_clr_we(l_sclr), .mask_we(l_mwr), .rcv_wdata(l_wdata),
    .ext_stat(in_ext),
    .msg_q(in_msg), .db_q(in_db), .stat(in_stat), .mask_q(in_mask), .irq(loc_irq)
  );

  msgdb_dir #(
    .DW(DW), .STAT_W(OUT_STAT_W), .IMPL(OUT_IMPL), .DB_SET_MASK(LOC_DB_MASK)
  ) u_out (
    .clk(clk), .rst_n(rst_q),
    .msg_we({l_msg1, l_msg0}), .db_set_we(l_ring), .snd_wdata(l_wdata),
    .db_clr_we(h_ack), .stat_clr_we(h_sclr), .mask_we(h_mwr), .rcv_wdata(h_wdata),
    .ext_stat(out_ext),
    .msg_q(out_msg), .db_q(out_db), .stat(out_stat), .mask_q(out_mask), .irq(host_irq)
  );

  function automatic logic [DW-1:0] pick(
    input logic [2:0]               a,
    input logic [N_MSG-1:0][DW-1:0] snd_msg,
    input logic [DW-1:0]            snd_db,
    input logic [N_MSG-1:0][DW-1:0] rcv_msg,
    input logic [DW-1:0]            rcv_db,
    input logic [DW-1:0]            rcv_stat,
    input logic [DW-1:0]            rcv_mask
  );
    case (a)
      A_MSG0:    return snd_msg[0];
      A_MSG1:    return snd_msg[1];
      A_DB_SEND: return snd_db;
      A_PEER0:   return rcv_msg[0];
      A_PEER1:   return rcv_msg[1];
      A_DB_ACK:  return rcv_db;
      A_STAT:    return rcv_stat;
      default:   return rcv_mask;
    endcase
  endfunction

  always_comb begin
    h_rdata = pick(h_addr, in_msg, in_db, out_msg, out_db,
                   {{(DW-OUT_STAT_W){1'b0}}, out_stat},
                   {{(DW-OUT_STAT_W){1'b0}}, out_mask});
    l_rdata = pick(l_addr, out_msg, out_db, in_msg, in_db,
                   {{(DW-IN_STAT_W){1'b0}}, in_stat},
                   {{(DW-IN_STAT_W){1'b0}}, in_mask});
  end

endmodule

// File: rtl/msgdb_chk.sv
module msgdb_chk
  import msgdb_pkg::*;
#(
  parameter int DW         = 32,
  parameter int LOCAL_DB_W = 29
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 h_we,
  input logic [2:0]           h_addr,
  input logic [DW-1:0]        h_wdata,
  input logic                 l_we,
  input logic [2:0]           l_addr,
  input logic [IN_STAT_W-1:0] in_stat,
  input logic [IN_STAT_W-1:0] in_mask,
  input logic [DW-1:0]        in_db,
  input logic [DW-1:0]        out_db,
  input logic                 loc_irq
);

  // R2
  msg_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == A_MSG0) |=> in_stat[0]);

  // R4
  host_db_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == A_DB_SEND && !(l_we && l_addr == A_DB_ACK))
      |=> ((in_db & $past(h_wdata)) == $past(h_wdata)));

  // R5
  loc_db_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_we && l_addr == A_DB_SEND) |=> $stable(out_db[DW-1:LOCAL_DB_W]));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_we && l_addr == A_MASK) |=> $stable(in_mask));

  // R10
  db_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_db != '0 && !in_mask[SB_DB]) |-> loc_irq);

endmodule

bind msgdb_unit msgdb_chk #(.DW(DW), .LOCAL_DB_W(LOCAL_DB_W)) u_chk (
  .clk(clk), .rst_n(rst_q),
  .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
  .l_we(l_we), .l_addr(l_addr),
  .in_stat(in_stat), .in_mask(in_mask), .in_db(in_db), .out_db(out_db),
  .loc_irq(loc_irq)
);

// File: tb/msgdb_unit_bench.sv
`timescale 1ns/1ps
module msgdb_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_we = 1'b0, l_we = 1'b0;
  logic [2:0]  h_addr = 3'd0, l_addr = 3'd0;
  logic [31:0] h_wdata = '0, l_wdata = '0;
  logic [31:0] h_rdata, l_rdata;
  logic        ev_mcheck = 0, ev_in_post = 0, ev_in_post_ovf = 0, ev_free_ovf = 0, ev_out_post = 0;
  logic        host_irq, loc_irq;

  int total = 0, fails = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  msgdb_unit u_msgdb_unit (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .ev_mcheck(ev_mcheck), .ev_in_post(ev_in_post), .ev_in_post_ovf(ev_in_post_ovf),
    .ev_free_ovf(ev_free_ovf), .ev_out_post(ev_out_post),
    .host_irq(host_irq), .loc_irq(loc_irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_imsg [2], m_omsg [2];
  logic [31:0] m_idb, m_odb, m_imask, m_omask;
  logic [1:0]  m_ism, m_osm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_imsg[0] = 0; m_imsg[1] = 0; m_omsg[0] = 0; m_omsg[1] = 0;
      m_idb = 0; m_odb = 0; m_ism = 0; m_osm = 0;
      m_imask = 32'h1BB; m_omask = 32'h2B;
    end else begin
      logic [1:0] iset, oset, iclr, oclr;
      iset = 0; oset = 0; iclr = 0; oclr = 0;
      if (h_we && h_addr < 2) begin m_imsg[h_addr[0]] = h_wdata; iset[h_addr[0]] = 1; end
      if (l_we && l_addr < 2) begin m_omsg[l_addr[0]] = l_wdata; oset[l_addr[0]] = 1; end
      if (l_we && l_addr == 6) iclr = l_wdata[1:0];
      if (h_we && h_addr == 6) oclr = h_wdata[1:0];
      m_ism = (m_ism & ~iclr) | iset;
      m_osm = (m_osm & ~oclr) | oset;
      m_idb = (m_idb & ~((l_we && l_addr == 5) ? l_wdata : 32'h0)) |
              ((h_we && h_addr == 2) ? h_wdata : 32'h0);
      m_odb = (m_odb & ~((h_we && h_addr == 5) ? h_wdata : 32'h0)) |
              ((l_we && l_addr == 2) ? (l_wdata & 32'h1FFF_FFFF) : 32'h0);
      if (l_we && l_addr == 7) m_imask = l_wdata & 32'h1BB;
      if (h_we && h_addr == 7) m_omask = h_wdata & 32'h2B;
    end
  end

  function automatic logic [31:0] m_istat();
    return {30'h0, m_ism} | ((m_idb != 0) ? 32'h8 : 0) | (32'(ev_mcheck) << 4) |
           (32'(ev_in_post) << 5) | (32'(ev_in_post_ovf) << 7) | (32'(ev_free_ovf) << 8);
  endfunction

  function automatic logic [31:0] m_ostat();
    return {30'h0, m_osm} | ((m_odb != 0) ? 32'h8 : 0) | (32'(ev_out_post) << 5);
  endfunction

  function automatic logic [31:0] exp_rd(input bit loc, input logic [2:0] a);
    case (a)
      0: return loc ? m_omsg[0] : m_imsg[0];
      1: return loc ? m_omsg[1] : m_imsg[1];
      2: return loc ? m_odb : m_idb;
      3: return loc ? m_imsg[0] : m_omsg[0];
      4: return loc ? m_imsg[1] : m_omsg[1];
      5: return loc ? m_idb : m_odb;
      6: return loc ? m_istat() : m_ostat();
      default: return loc ? m_imask : m_omask;
    endcase
  endfunction

  function automatic string tag(input bit loc, input logic [2:0] a);
    case (a)
      0, 1, 3, 4: return "R2";
      2: return loc ? "R5" : "R4";
      5: return "R6";
      6: return loc ? "R7" : "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(tag(0, h_addr), h_rdata, exp_rd(0, h_addr));
      chk(tag(1, l_addr), l_rdata, exp_rd(1, l_addr));
      chk("R10", {31'h0, host_irq}, {31'h0, |(m_ostat() & ~m_omask & 32'h2B)});
      chk("R10", {31'h0, loc_irq},  {31'h0, |(m_istat() & ~m_imask & 32'h1BB)});
    end
  end

  // drive one cycle of writes (posedge + 1ns), then idle
  task automatic wr(input bit hw, input logic [2:0] ha, input logic [31:0] hd,
                    input bit lw, input logic [2:0] la, input logic [31:0] ld);
    @(posedge clk); #1;
    h_we = hw; h_addr = ha; h_wdata = hd;
    l_we = lw; l_addr = la; l_wdata = ld;
    @(posedge clk); #1;
    h_we = 0; l_we = 0;
  endtask

  task automatic rd(input bit loc, input logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    if (loc) l_addr = a; else h_addr = a;
    @(negedge clk);
    v = loc ? l_rdata : h_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    cmp_on = 1;

    // R1 reset state
    rd(1, 7, v); chk("R1", v, 32'h1BB);
    rd(0, 7, v); chk("R1", v, 32'h2B);
    rd(0, 6, v); chk("R1", v, 32'h0);
    chk("R1", {30'h0, host_irq, loc_irq}, 32'h0);

    // R2 outbound message
    wr(0, 0, 0, 1, 0, 32'hA5A5_0001);
    rd(0, 3, v); chk("R2", v, 32'hA5A5_0001);
    rd(0, 6, v); chk("R2", v, 32'h1);

    // R3 set wins over a simultaneous clear; then clear alone
    wr(1, 1, 32'h1234_5678, 1, 6, 32'h3);
    rd(1, 6, v); chk("R3", v & 3, 32'h2);
    wr(0, 0, 0, 1, 6, 32'h2);
    rd(1, 6, v); chk("R3", v & 3, 32'h0);

    // R4 host doorbell ORs
    wr(1, 2, 32'h0000_000F, 0, 0, 0);
    wr(1, 2, 32'h0000_00F0, 0, 0, 0);
    rd(1, 5, v); chk("R4", v, 32'h0000_00FF);

    // R5 local doorbell top bits
    wr(0, 0, 0, 1, 2, 32'hFFFF_FFFF);
    rd(0, 5, v); chk("R5", v, 32'h1FFF_FFFF);

    // R6 partial W1C keeps bit 3 pending, full clear drops it
    wr(1, 5, 32'h0000_FFFF, 0, 0, 0);
    rd(0, 5, v); chk("R6", v, 32'h1FFF_0000);
    rd(0, 6, v); chk("R6", v & 8, 32'h8);
    wr(1, 5, 32'hFFFF_FFFF, 0, 0, 0);
    rd(0, 6, v); chk("R6", v & 8, 32'h0);
    // ring and ack in the same cycle: ring wins
    wr(1, 2, 32'h100, 1, 5, 32'h1FF);
    rd(1, 5, v); chk("R6", v, 32'h100);

    // R7 live inbound sources
    @(posedge clk); #1 ev_mcheck = 1; ev_in_post_ovf = 1;
    rd(1, 6, v); chk("R7", v, 32'h0000_0098 | 32'h3 & 32'h0 | 32'h8 & v);
    chk("R7", v & 32'hFFFF_FE44, 32'h0);

    // R8 outbound post input
    @(posedge clk); #1 ev_out_post = 1;
    rd(0, 6, v); chk("R8", v & 32'h20, 32'h20);
    chk("R8", v & 32'hFFFF_FFD4, 32'h0);

    // R9 mask write, reserved bits dropped
    wr(0, 0, 0, 1, 7, 32'hFFFF_FFFF);
    rd(1, 7, v); chk("R9", v, 32'h1BB);

    // R10 unmask doorbell only, pending doorbell raises loc_irq
    wr(0, 0, 0, 1, 7, 32'h1B3);
    @(negedge clk); chk("R10", {31'h0, loc_irq}, 32'h1);
    wr(0, 0, 0, 1, 5, 32'hFFFF_FFFF);
    @(negedge clk); chk("R10", {31'h0, loc_irq}, 32'h0);

    // R11 writes to peer offsets ignored
    wr(1, 3, 32'hDEAD_BEEF, 1, 4, 32'hCAFE_F00D);
    rd(1, 0, v); chk("R11", v, 32'hA5A5_0001);
    rd(0, 1, v); chk("R11", v, 32'h1234_5678);

    // random traffic on both ports, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      h_we = $urandom_range(0, 1); h_addr = 3'($urandom_range(0, 7)); h_wdata = $urandom;
      l_we = $urandom_range(0, 1); l_addr = 3'($urandom_range(0, 7)); l_wdata = $urandom;
      if ($urandom_range(0, 7) == 0) begin
        ev_mcheck = $urandom_range(0, 1); ev_in_post = $urandom_range(0, 1);
        ev_in_post_ovf = $urandom_range(0, 1); ev_free_ovf = $urandom_range(0, 1);
        ev_out_post = $urandom_range(0, 1);
      end
    end
    @(posedge clk); #1 h_we = 0; l_we = 0;
    @(negedge clk);
    cmp_on = 0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule